// File: doc/BRIEF.md
# Separate-Port Two-Word Burst Memory

This block is a synchronous memory with a dedicated read port and a dedicated write port. The two ports share one address bus, and they take turns on it. The design runs on a single clock at the word rate, which is twice the reference rate. An internal phase bit splits each reference cycle into two slots. In the slot where the phase is 0, the address bus carries the read address. In the slot where the phase is 1, it carries the write address. The phase bit is brought out so that the host can line up its slots with the block.

Every access moves a fixed pair of words tied to one address. On a write, the two data words follow the write address in the next two slots, each with its own active-low byte enables. Once both words are held, the pair waits one clock in a pending register and is then committed to the array. On a read, the pair leaves the block on a separate output bus, one word per clock, with a valid flag beside each word. The read port keeps the data coherent: a read returns the newest data for its address, even when the latest write to that address is still in the pending register.

Top module: `burst_pair_mem`

## Requirements
- R1: While reset is high, and in the first slot after it falls, `rdValid` is 0 and `phase` is 0. Reset does not clear the array.
- R2: `phase` toggles on every clock. An edge sampled with `phase`=0 is a read-address slot, and an edge sampled with `phase`=1 is a write-address slot.
- R3: A read captured at edge t drives word 0 of the pair on `rdData` with `rdValid`=1 after edge t+3, and word 1 after edge t+4.
- R4: A write captured at edge t takes data word 0 at edge t+1 and data word 1 at edge t+2. The pair is then stored at that address.
- R5: `wrByteEnN` is active low, with one bit per byte lane: bit i covers `wrData[8i+7:8i]`. Each data word uses the enables sampled with it. Lanes that are not enabled keep their previous contents.
- R6: When `rdSelN` is high in a read slot, no read takes place and `rdValid` stays 0 in that slot's output cycles. `rdSelN` has no effect in write slots.
- R7: When `wrSelN` is high in a write slot, the memory is not changed, whatever appears on `wrData`. `wrSelN` has no effect in read slots.
- R8: A read returns the newest data for its address. This includes a write captured in the slot just before the read, whose pair has not yet been committed. Only that write's enabled byte lanes are merged into the result.
- R9: A location that has never been written reads as all zeros.
- R10: When reads are issued in back-to-back reference cycles, `rdValid` stays high without gaps, and every pair comes out in issue order, alongside concurrent writes to any addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| phase | output | 1 | Slot marker: 0 = read-address slot, 1 = write-address slot |
| addr | input | ADDR_W | Shared address bus, read in both slots |
| rdSelN | input | 1 | Read port select, active low, used in read slots |
| wrSelN | input | 1 | Write port select, active low, used in write slots |
| wrData | input | WORD_W | Write data, one word per clock |
| wrByteEnN | input | WORD_W/BYTE_W | Per-lane write enables for the current data word, active low |
| rdData | output | WORD_W | Read data, one word per clock |
| rdValid | output | 1 | Marks a valid word on rdData |

## Verification
The assertions assume that the host drives every input with known values at each edge after reset. They also assume that the host holds the slot order given by `phase`, so that the select sampled in each slot is the one meant for that slot. The stimulus changes inputs only at falling edges. Before each slot it checks the `phase` it sees, and it always drives defined data and enables, even when no write is pending. In the slots where a select is meant to be ignored, the stimulus drives that select active on purpose.

// File: rtl/bpm_pkg.sv
package bpm_pkg;
  // Strobes from the control unit; each acts at the next rising edge.
  typedef struct packed {
    logic capRd;   // capture read address
    logic capWr;   // capture write address
    logic takeW0;  // hold first write word
    logic takeW1;  // move full pair into pending register
    logic commit;  // pending pair valid: write to array this edge
    logic lookup;  // fetch read pair (with forwarding)
    logic emitW0;  // drive first read word
    logic emitW1;  // drive second read word
  } ctrlStrb_t;
endpackage

// File: rtl/bpm_ctrl.sv
module bpm_ctrl
  import bpm_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      rdSelN,
  input  logic      wrSelN,
  output logic      phase,
  output logic      rdValid,
  output ctrlStrb_t strb
);
  logic rdS1, rdS2, lookDone, emitDone;
  logic wrArm, wrHalf, pendValid;

  always_comb begin
    strb.capRd  = !phase && !rdSelN;
    strb.capWr  = phase && !wrSelN;
    strb.takeW0 = wrArm;
    strb.takeW1 = wrHalf;
    strb.commit = pendValid;
    strb.lookup = rdS2;
    strb.emitW0 = lookDone;
    strb.emitW1 = emitDone;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= 1'b0;
      rdS1      <= 1'b0;
      rdS2      <= 1'b0;
      lookDone  <= 1'b0;
      emitDone  <= 1'b0;
      wrArm     <= 1'b0;
      wrHalf    <= 1'b0;
      pendValid <= 1'b0;
      rdValid   <= 1'b0;
    end else begin
      phase     <= ~phase;
      rdS1      <= strb.capRd;
      rdS2      <= rdS1;
      lookDone  <= rdS2;
      emitDone  <= lookDone;
      wrArm     <= strb.capWr;
      wrHalf    <= wrArm;
      pendValid <= wrHalf;
      rdValid   <= lookDone || emitDone;
    end
  end
endmodule

// File: rtl/bpm_datapath.sv
module bpm_datapath
  import bpm_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int WORD_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic                       clk,
  input  ctrlStrb_t                  strb,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [WORD_W-1:0]          wrData,
  input  logic [WORD_W/BYTE_W-1:0]   wrByteEnN,
  output logic [WORD_W-1:0]          rdData
);
  localparam int LANES = WORD_W / BYTE_W;
  localparam int DEPTH = 1 << ADDR_W;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LANES-1:0]  mask_t;

  word_t memLo [DEPTH];
  word_t memHi [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      memLo[i] = '0;
      memHi[i] = '0;
    end
  end

  logic [ADDR_W-1:0] rdAddrQ, wrAddrQ, pendAddr;
  word_t w0Q, pendLo, pendHi, outLo, outHi;
  mask_t m0Q, pendMaskLo, pendMaskHi;
  word_t arrLo, arrHi, fwdLo, fwdHi;
  logic  pendHit;

  assign arrLo   = memLo[rdAddrQ];
  assign arrHi   = memHi[rdAddrQ];
  assign pendHit = strb.commit && (pendAddr == rdAddrQ);

  // Per-lane merge of the uncommitted pair over the array contents.
  for (genvar l = 0; l < LANES; l++) begin : g_fwd
    assign fwdLo[l*BYTE_W +: BYTE_W] = (pendHit && pendMaskLo[l]) ?
        pendLo[l*BYTE_W +: BYTE_W] : arrLo[l*BYTE_W +: BYTE_W];
    assign fwdHi[l*BYTE_W +: BYTE_W] = (pendHit && pendMaskHi[l]) ?
        pendHi[l*BYTE_W +: BYTE_W] : arrHi[l*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (strb.capRd) rdAddrQ <= addr;
    if (strb.capWr) wrAddrQ <= addr;
    if (strb.takeW0) begin
      w0Q <= wrData;
      m0Q <= ~wrByteEnN;
    end
    if (strb.takeW1) begin
      pendAddr   <= wrAddrQ;
      pendLo     <= w0Q;
      pendMaskLo <= m0Q;
      pendHi     <= wrData;
      pendMaskHi <= ~wrByteEnN;
    end
    if (strb.commit) begin
      for (int l = 0; l < LANES; l++) begin
        if (pendMaskLo[l]) memLo[pendAddr][l*BYTE_W +: BYTE_W] <= pendLo[l*BYTE_W +: BYTE_W];
        if (pendMaskHi[l]) memHi[pendAddr][l*BYTE_W +: BYTE_W] <= pendHi[l*BYTE_W +: BYTE_W];
      end
    end
    if (strb.lookup) begin
      outLo <= fwdLo;
      outHi <= fwdHi;
    end
    if (strb.emitW0)      rdData <= outLo;
    else if (strb.emitW1) rdData <= outHi;
    else                  rdData <= '0;
  end
endmodule

// File: rtl/burst_pair_mem.sv
module burst_pair_mem
  import bpm_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int WORD_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  output logic                     phase,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     rdSelN,
  input  logic                     wrSelN,
  input  logic [WORD_W-1:0]        wrData,
  input  logic [WORD_W/BYTE_W-1:0] wrByteEnN,
  output logic [WORD_W-1:0]        rdData,
  output logic                     rdValid
);
  ctrlStrb_t strb;

  bpm_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .rdSelN  (rdSelN),
    .wrSelN  (wrSelN),
    .phase   (phase),
    .rdValid (rdValid),
    .strb    (strb)
  );

  bpm_datapath #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W),
    .BYTE_W (BYTE_W)
  ) u_dp (
    .clk       (clk),
    .strb      (strb),
    .addr      (addr),
    .wrData    (wrData),
    .wrByteEnN (wrByteEnN),
    .rdData    (rdData)
  );
endmodule

// File: rtl/burst_pair_mem_chk.sv
module burst_pair_mem_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              phase,
  input logic              rdSelN,
  input logic              wrSelN,
  input logic [WORD_W-1:0] rdData,
  input logic              rdValid,
  input logic              commitStrb
);
  // R2
  phase_fall_chk: assert property (@(posedge clk) disable iff (rst)
    phase |=> !phase);
  // R2
  phase_rise_chk: assert property (@(posedge clk) disable iff (rst)
    !phase |=> phase);
  // R3
  read_lat_chk: assert property (@(posedge clk) disable iff (rst)
    (!phase && !rdSelN) |=> ##3 rdValid ##1 rdValid);
  // R6
  no_read_chk: assert property (@(posedge clk) disable iff (rst)
    (!phase && rdSelN) |=> ##3 !rdValid ##1 !rdValid);
  // R4
  write_commit_chk: assert property (@(posedge clk) disable iff (rst)
    (phase && !wrSelN) |=> ##2 commitStrb);
  // R7
  no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (phase && wrSelN) |=> ##2 !commitStrb);
  // R9
  data_known_chk: assert property (@(posedge clk) disable iff (rst)
    rdValid |-> !$isunknown(rdData));
endmodule

bind burst_pair_mem burst_pair_mem_chk #(.WORD_W(WORD_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .phase      (phase),
  .rdSelN     (rdSelN),
  .wrSelN     (wrSelN),
  .rdData     (rdData),
  .rdValid    (rdValid),
  .commitStrb (strb.commit)
);

// File: tb/burst_pair_mem_tb.sv
`timescale 1ns/1ps
module burst_pair_mem_tb;
  localparam int AW = 4;
  localparam int W  = 16;
  localparam int BW = 8;
  localparam int L  = W / BW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic phase;
  logic [AW-1:0] addr = '0;
  logic rdSelN = 1'b1, wrSelN = 1'b1;
  logic [W-1:0] wrData = '0;
  logic [L-1:0] wrByteEnN = '1;
  logic [W-1:0] rdData;
  logic rdValid;

  always #2.5 clk = ~clk;

  burst_pair_mem #(.ADDR_W(AW), .WORD_W(W), .BYTE_W(BW)) u_dut (
    .clk(clk), .rst(rst), .phase(phase), .addr(addr), .rdSelN(rdSelN),
    .wrSelN(wrSelN), .wrData(wrData), .wrByteEnN(wrByteEnN),
    .rdData(rdData), .rdValid(rdValid)
  );

  logic [W-1:0] modLo [1<<AW];
  logic [W-1:0] modHi [1<<AW];
  logic [W-1:0] expQ [$];
  string        tagQ [$];
  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  bit pwOn = 0;
  logic [W-1:0] pw0, pw1;
  logic [L-1:0] pk0, pk1; // active-high masks

  task automatic check(bit ok, string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] merge(logic [W-1:0] old, logic [W-1:0] nw, logic [L-1:0] m);
    logic [W-1:0] r = old;
    for (int l = 0; l < L; l++) if (m[l]) r[l*BW +: BW] = nw[l*BW +: BW];
    return r;
  endfunction

  // Scoreboard monitor: compares every valid word against the queue.
  always @(negedge clk) begin
    if (!rst && rdValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R6 unexpected valid", rdData, '0);
      end else begin
        automatic logic [W-1:0] e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        check(rdData === e, t, rdData, e);
      end
    end
  end

  // One reference cycle: read slot, then write slot. Also delivers data of the previous write.
  task automatic refCycle(bit rdOn, logic [AW-1:0] rdA, bit wrOn, logic [AW-1:0] wrA,
                          logic [W-1:0] n0, logic [W-1:0] n1,
                          logic [L-1:0] k0, logic [L-1:0] k1, string tag);
    if (rdOn) begin
      expQ.push_back(modLo[rdA]); tagQ.push_back({tag, " word0"});
      expQ.push_back(modHi[rdA]); tagQ.push_back({tag, " word1"});
    end
    if (wrOn) begin
      modLo[wrA] = merge(modLo[wrA], n0, k0);
      modHi[wrA] = merge(modHi[wrA], n1, k1);
    end
    check(phase == 1'b0, "R2 read slot phase", {15'd0, phase}, '0);
    addr      = rdA;
    rdSelN    = !rdOn;
    wrSelN    = 1'b0;           // ignored in read slot (R7)
    wrData    = pwOn ? pw0 : W'($urandom);
    wrByteEnN = pwOn ? ~pk0 : L'($urandom);
    @(negedge clk);
    check(phase == 1'b1, "R2 write slot phase", {15'd0, phase}, 16'd1);
    addr      = wrA;
    wrSelN    = !wrOn;
    rdSelN    = 1'b0;           // ignored in write slot (R6)
    wrData    = pwOn ? pw1 : W'($urandom);
    wrByteEnN = pwOn ? ~pk1 : L'($urandom);
    @(negedge clk);
    pwOn = wrOn; pw0 = n0; pw1 = n1; pk0 = k0; pk1 = k1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) refCycle(0, '0, 0, '0, '0, '0, '0, '0, "idle");
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < (1<<AW); i++) begin modLo[i] = '0; modHi[i] = '0; end
    repeat (4) @(negedge clk);
    check(rdValid == 1'b0, "R1 valid in reset", {15'd0, rdValid}, '0);
    check(phase == 1'b0, "R1 phase in reset", {15'd0, phase}, '0);
    rst = 1'b0;
    // R9: untouched location reads zero
    refCycle(1, 4'd3, 0, '0, '0, '0, '0, '0, "R9 unwritten");
    // R4: full write, read later
    refCycle(0, '0, 1, 4'd5, 16'hA1B2, 16'hC3D4, 2'b11, 2'b11, "R4 write");
    idle(2);
    refCycle(1, 4'd5, 0, '0, '0, '0, '0, '0, "R4 readback");
    // R8: read right after write to same address, then partial overwrite merged
    refCycle(0, '0, 1, 4'd7, 16'h1111, 16'h2222, 2'b11, 2'b11, "R8 w");
    refCycle(1, 4'd7, 1, 4'd7, 16'hAAAA, 16'hBBBB, 2'b01, 2'b10, "R8 fwd full");
    refCycle(1, 4'd7, 0, '0, '0, '0, '0, '0, "R5 R8 fwd merge");
    idle(2);
    refCycle(1, 4'd7, 0, '0, '0, '0, '0, '0, "R5 lanes after commit");
    // R7: deselected write with random data on the bus
    refCycle(0, '0, 0, 4'd2, '0, '0, '0, '0, "R7 no write");
    idle(2);
    refCycle(1, 4'd2, 0, '0, '0, '0, '0, '0, "R7 unchanged");
    // R6: reads deselected produce no output
    refCycle(0, 4'd5, 0, '0, '0, '0, '0, '0, "R6");
    idle(2);
    // R10: back-to-back reads with concurrent random writes
    for (int i = 0; i < 400; i++) begin
      refCycle(($urandom % 4) != 0, AW'($urandom % 4), ($urandom % 2) == 1, AW'($urandom % 4),
               W'($urandom), W'($urandom), L'($urandom), L'($urandom), "R10 R8 stream");
    end
    idle(4);
    check(expQ.size() == 0, "R3 all reads returned", W'(expQ.size()), '0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule